// File: doc/BRIEF.md
# Mode Register Pointer Access Unit

This unit serves one serial channel. It stores two 8-bit mode registers, called the first and the second mode register. Both are reached through a single host bus address. An internal one-bit pointer picks which of the two an access reaches. Any access to the first mode register moves the pointer to the second. The pointer then stays on the second mode register until reset, or until a pointer-return command is written to a separate write-only command address.

The unit also holds a clock-select register. Its upper nibble selects the receive clock and its lower nibble selects the transmit clock. All three registers, and the fields decoded from the second mode register, are driven out as plain levels to the channel logic.

The host bus is synchronous. An access is one cycle with `bus_sel_i` high. `bus_we_i` chooses write or read. Read data is registered and appears on `bus_rdata_o` one cycle after the read.

Top module: `mode_ptr_regs`

## Requirements
- R1: During and after reset, the pointer selects the first mode register, and the first mode register, second mode register, clock-select register and `bus_rdata_o` are all zero.
- R2: When the pointer selects the first mode register, an access to the mode address (0) reads or writes the first mode register, and the pointer then selects the second. Reads and writes both advance the pointer.
- R3: When the pointer selects the second mode register, an access to the mode address reads or writes the second mode register, and the pointer does not change.
- R4: A write to the command address (2) with bits 7:4 equal to 0x1 makes the pointer select the first mode register. Bits 3:0 of that write are ignored.
- R5: A write to the command address with any other value in bits 7:4 leaves the pointer and all registers unchanged.
- R6: A write to the clock-select address (1) stores the byte. Bits 7:4 drive `rx_clk_sel_o`, bits 3:0 drive `tx_clk_sel_o`, and a read of that address returns the stored byte.
- R7: `cts_gate_en_o` equals bit 4 of the second mode register, and `stop_len_o` equals bits 3:2 of the second mode register.
- R8: Read data appears on `bus_rdata_o` one cycle after the read and holds until the next read. A read of the command address returns 0x00.
- R9: With `bus_sel_i` low, no register, no pointer state and no read data changes, whatever the other bus inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 mode, 1 clock select, 2 command |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| mode1_o | output | 8 | First mode register contents |
| mode2_o | output | 8 | Second mode register contents |
| rx_clk_sel_o | output | 4 | Receive clock select |
| tx_clk_sel_o | output | 4 | Transmit clock select |
| cts_gate_en_o | output | 1 | Clear-to-send gating enable |
| stop_len_o | output | 2 | Stop-bit length code |

## Verification
In a single cycle, an access to the first mode register both moves data (a capture or a read) and advances the pointer at the same edge. If the unit decoded the pointer after it had already moved, the access would land in the second mode register.

The vector table provokes this in three ways:
- back-to-back mode-address reads, which must return the first register and then the second;
- a write that follows a pointer-return command;
- a read right after a write to the first mode register.

Each case is judged by the value read back and by the `mode1_o` and `mode2_o` levels.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic {
        PTR_MR1 = 1'b0,
        PTR_MR2 = 1'b1
    } mode_ptr_e;

    typedef struct packed {
        logic hit_mode;
        logic hit_clk;
        logic hit_cmd;
        logic rd;
        logic wr;
    } bus_dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] mr1;
        logic [DATA_W-1:0] mr2;
        logic [DATA_W-1:0] csr;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    typedef struct packed {
        mode_ptr_e ptr;
    } ptr_state_t;
endpackage

// File: rtl/mrp_decode.sv
module mrp_decode #(
    parameter int ADDR_W    = 2,
    parameter int MODE_ADDR = 0,
    parameter int CLK_ADDR  = 1,
    parameter int CMD_ADDR  = 2
) (
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output mrp_pkg::bus_dec_t dec_o
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] CLK_A  = ADDR_W'(CLK_ADDR);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);

    always_comb begin
        dec_o          = '0;
        dec_o.rd       = sel_i && !we_i;
        dec_o.wr       = sel_i && we_i;
        dec_o.hit_mode = sel_i && (addr_i == MODE_A);
        dec_o.hit_clk  = sel_i && (addr_i == CLK_A);
        dec_o.hit_cmd  = sel_i && (addr_i == CMD_A);
    end

    always_comb begin
        if (!sel_i) begin
            a_r9_no_hit_idle: assert (!(dec_o.hit_mode || dec_o.hit_clk || dec_o.hit_cmd));
        end
        a_dec_onehot: assert ($countones({dec_o.hit_mode, dec_o.hit_clk, dec_o.hit_cmd}) <= 1);
    end
endmodule

// File: rtl/mrp_ptr.sv
module mrp_ptr #(
    parameter logic [mrp_pkg::NIB_W-1:0] RST_PTR_CODE = 4'h1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  mrp_pkg::bus_dec_t           dec_i,
    input  logic [mrp_pkg::NIB_W-1:0]   cmd_code_i,
    output mrp_pkg::mode_ptr_e          ptr_o
);
    import mrp_pkg::*;

    ptr_state_t st_d, st_q;
    logic       cmd_rst;

    always_comb begin
        st_d    = st_q;
        cmd_rst = dec_i.hit_cmd && dec_i.wr && (cmd_code_i == RST_PTR_CODE);
        if (cmd_rst) begin
            st_d.ptr = PTR_MR1;
        end else if (dec_i.hit_mode && st_q.ptr == PTR_MR1) begin
            st_d.ptr = PTR_MR2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ptr: PTR_MR1};
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;

    // R2: a mode access from the first register moves the pointer forward
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i.hit_mode && ptr_o == PTR_MR1) |=> (ptr_o == PTR_MR2));
    // R3: a mode access from the second register keeps it there
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i.hit_mode && ptr_o == PTR_MR2) |=> (ptr_o == PTR_MR2));
    // R4: the return command brings the pointer back
    a_r4_cmd_return: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i.hit_cmd && dec_i.wr && cmd_code_i == RST_PTR_CODE) |=> (ptr_o == PTR_MR1));
    // R5/R9: without a mode access or a matching command, the pointer is stable
    a_r5_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i.hit_mode && !(dec_i.hit_cmd && dec_i.wr && cmd_code_i == RST_PTR_CODE))
        |=> $stable(ptr_o));
endmodule

// File: rtl/mrp_regs.sv
module mrp_regs (
    input  logic                         clk,
    input  logic                         rst_n,
    input  mrp_pkg::bus_dec_t            dec_i,
    input  mrp_pkg::mode_ptr_e           ptr_i,
    input  logic [mrp_pkg::DATA_W-1:0]   wdata_i,
    output logic [mrp_pkg::DATA_W-1:0]   mr1_o,
    output logic [mrp_pkg::DATA_W-1:0]   mr2_o,
    output logic [mrp_pkg::DATA_W-1:0]   csr_o,
    output logic [mrp_pkg::DATA_W-1:0]   rdata_o
);
    import mrp_pkg::*;

    regs_t r_d, r_q;
    logic  sel_mr1, sel_mr2;

    always_comb begin
        r_d     = r_q;
        sel_mr1 = dec_i.hit_mode && (ptr_i == PTR_MR1);
        sel_mr2 = dec_i.hit_mode && (ptr_i == PTR_MR2);
        if (dec_i.wr) begin
            if (sel_mr1)       r_d.mr1 = wdata_i;
            if (sel_mr2)       r_d.mr2 = wdata_i;
            if (dec_i.hit_clk) r_d.csr = wdata_i;
        end
        if (dec_i.rd) begin
            if (sel_mr1)            r_d.rdata = r_q.mr1;
            else if (sel_mr2)       r_d.rdata = r_q.mr2;
            else if (dec_i.hit_clk) r_d.rdata = r_q.csr;
            else                    r_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mr1_o   = r_q.mr1;
    assign mr2_o   = r_q.mr2;
    assign csr_o   = r_q.csr;
    assign rdata_o = r_q.rdata;

    // R8: read data holds when no read happens
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_i.rd |=> $stable(rdata_o));
    // R9: no register moves when no write hits it
    a_r9_regs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_i.wr |=> ($stable(mr1_o) && $stable(mr2_o) && $stable(csr_o)));
    // R3: a write reaching the second register leaves the first untouched
    a_r3_mr1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i.wr && dec_i.hit_mode && ptr_i == PTR_MR2) |=> $stable(mr1_o));
    // R5: a command write changes no stored register
    a_r5_cmd_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i.hit_cmd |=> ($stable(mr1_o) && $stable(mr2_o) && $stable(csr_o)));
endmodule

// File: rtl/mode_ptr_regs.sv
module mode_ptr_regs #(
    parameter int   ADDR_W       = 2,
    parameter int   MODE_ADDR    = 0,
    parameter int   CLK_ADDR     = 1,
    parameter int   CMD_ADDR     = 2,
    parameter logic [3:0] RST_PTR_CODE = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic [7:0]        mode1_o,
    output logic [7:0]        mode2_o,
    output logic [3:0]        rx_clk_sel_o,
    output logic [3:0]        tx_clk_sel_o,
    output logic              cts_gate_en_o,
    output logic [1:0]        stop_len_o
);
    import mrp_pkg::*;

    localparam int CTS_BIT  = 4;
    localparam int STOP_LSB = 2;

    bus_dec_t          dec;
    mode_ptr_e         ptr;
    logic [DATA_W-1:0] csr;

    mrp_decode #(
        .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR),
        .CLK_ADDR(CLK_ADDR), .CMD_ADDR(CMD_ADDR)
    ) u_dec (
        .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .dec_o(dec)
    );

    mrp_ptr #(.RST_PTR_CODE(RST_PTR_CODE)) u_ptr (
        .clk(clk), .rst_n(rst_n), .dec_i(dec),
        .cmd_code_i(bus_wdata_i[DATA_W-1:NIB_W]), .ptr_o(ptr)
    );

    mrp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .dec_i(dec), .ptr_i(ptr),
        .wdata_i(bus_wdata_i), .mr1_o(mode1_o), .mr2_o(mode2_o),
        .csr_o(csr), .rdata_o(bus_rdata_o)
    );

    assign rx_clk_sel_o  = csr[DATA_W-1:NIB_W];
    assign tx_clk_sel_o  = csr[NIB_W-1:0];
    assign cts_gate_en_o = mode2_o[CTS_BIT];
    assign stop_len_o    = mode2_o[STOP_LSB+1:STOP_LSB];

    // R1: one cycle after reset the outputs are cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (mode1_o == '0 && mode2_o == '0 && csr == '0 && bus_rdata_o == '0));
    // R6: a clock-select write is visible on both fields next cycle
    a_r6_clk_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(CLK_ADDR))
        |=> ({rx_clk_sel_o, tx_clk_sel_o} == $past(bus_wdata_i)));
endmodule

// File: tb/test_mode_ptr_regs.sv
module test_mode_ptr_regs;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel_i, bus_we_i;
    logic [1:0] bus_addr_i;
    logic [7:0] bus_wdata_i, bus_rdata_o, mode1_o, mode2_o;
    logic [3:0] rx_clk_sel_o, tx_clk_sel_o;
    logic       cts_gate_en_o;
    logic [1:0] stop_len_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mode_ptr_regs i_mode_ptr_regs (.*);

    typedef struct packed {
        logic       we;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 4'd2}, // R2 read first register, pointer advances
        '{1'b1, 2'd0, 8'h1C, 1'b0, 8'h00, 4'd3}, // R3 write reaches the second register
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h1C, 4'd3}, // R3 pointer still on the second register
        '{1'b1, 2'd2, 8'h10, 1'b0, 8'h00, 4'd4}, // R4 return command
        '{1'b1, 2'd0, 8'hA5, 1'b0, 8'h00, 4'd2}, // R2 write reaches the first register
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h1C, 4'd2}, // R2 a write also advanced the pointer
        '{1'b1, 2'd2, 8'h20, 1'b0, 8'h00, 4'd5}, // R5 other command code
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h1C, 4'd5}, // R5 pointer was not moved
        '{1'b1, 2'd2, 8'h00, 1'b0, 8'h00, 4'd5}, // R5 code zero
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h1C, 4'd5},
        '{1'b1, 2'd2, 8'h1F, 1'b0, 8'h00, 4'd4}, // R4 low nibble ignored
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'hA5, 4'd4}, // R4 read returns the first register
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h1C, 4'd2}, // R2 back-to-back read reaches the second
        '{1'b1, 2'd1, 8'h3C, 1'b0, 8'h00, 4'd6}, // R6 clock-select write
        '{1'b0, 2'd1, 8'h00, 1'b1, 8'h3C, 4'd6}, // R6 clock-select readback
        '{1'b0, 2'd2, 8'h00, 1'b1, 8'h00, 4'd8}, // R8 command address reads zero
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h1C, 4'd3}  // R3 mode read stays on the second register
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] addr, input logic [7:0] wd);
        @(negedge clk);
        bus_sel_i   = 1'b1;
        bus_we_i    = we;
        bus_addr_i  = addr;
        bus_wdata_i = wd;
        @(negedge clk);
        bus_sel_i   = 1'b0;
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_sel_i = 1'b0;
        bus_we_i = 1'b0;
        bus_addr_i = '0;
        bus_wdata_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata_o, 8'h00);
        check("R1 mode1", mode1_o, 8'h00);
        check("R1 mode2", mode2_o, 8'h00);
        check("R1 clksel", {rx_clk_sel_o, tx_clk_sel_o}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].we, VEC[i].addr, VEC[i].wdata);
            if (VEC[i].chk) check($sformatf("R%0d vec%0d", VEC[i].req, i), bus_rdata_o, VEC[i].exp);
        end

        // R7 / R6: decoded levels
        check("R7 cts", {7'd0, cts_gate_en_o}, 8'h01);
        check("R7 stop", {6'd0, stop_len_o}, 8'h03);
        check("R6 rx", {4'd0, rx_clk_sel_o}, 8'h03);
        check("R6 tx", {4'd0, tx_clk_sel_o}, 8'h0C);
        check("R2 mode1", mode1_o, 8'hA5);

        // R8: read data holds through an idle cycle
        @(negedge clk);
        check("R8 hold", bus_rdata_o, 8'h1C);

        // R9: strobe low with live write inputs changes nothing
        bus_sel_i = 1'b0; bus_we_i = 1'b1; bus_addr_i = 2'd0; bus_wdata_i = 8'hFF;
        @(negedge clk);
        bus_addr_i = 2'd2; bus_wdata_i = 8'h10;
        @(negedge clk);
        bus_addr_i = 2'd1; bus_wdata_i = 8'hEE;
        @(negedge clk);
        check("R9 mode1", mode1_o, 8'hA5);
        check("R9 mode2", mode2_o, 8'h1C);
        check("R9 clksel", {rx_clk_sel_o, tx_clk_sel_o}, 8'h3C);
        check("R9 rdata", bus_rdata_o, 8'h1C);
        access(1'b0, 2'd0, 8'h00);
        check("R9 pointer kept", bus_rdata_o, 8'h1C);

        // R7: change the second register
        access(1'b1, 2'd0, 8'h08);
        check("R7 cts off", {7'd0, cts_gate_en_o}, 8'h00);
        check("R7 stop 2", {6'd0, stop_len_o}, 8'h02);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid mode1", mode1_o, 8'h00);
        check("R1 mid mode2", mode2_o, 8'h00);
        check("R1 mid rdata", bus_rdata_o, 8'h00);
        rst_n = 1'b1;
        access(1'b1, 2'd0, 8'h77);
        check("R1 pointer on first", mode1_o, 8'h77);
        check("R1 second untouched", mode2_o, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule